// File: doc/BRIEF.md
# Dynamic Loss-Scale Controller

This block keeps the loss scale of a half-precision training loop as a power of two and adjusts it by feedback from the gradients. A pulse on `step_start` opens a training step. The gradient words of that step then stream in as 16-bit half-precision values under `grad_valid`, and the final word also carries `grad_last`. Every accepted word is classified as finite or non-finite. One non-finite word is enough to mark the whole step as overflowed.

When the last word has been taken, the block issues a verdict. A commit lets the optimizer apply the update. A skip drops the update. The scale exponent for the next step moves at the same time. After a skip it falls by one. After a run of clean steps it rises by one. Only the exponent is stored, so the scale itself is 2^`scale_exp`. The exponent stays inside configured bounds. The growth run length comes from an input, and a value of zero on that input selects a built-in default.

Top module: `loss_scale_ctrl`

## Requirements
- R1: After reset, `scale_exp` equals INIT_EXP (15), and `decision_valid` and `overflow_flag` are 0.
- R2: An accepted word whose bits [14:10] are all ones counts as non-finite, whatever its sign bit and its mantissa bits [9:0]. This covers both infinity (mantissa zero) and NaN (mantissa non-zero). Any other word, including the largest finite magnitudes 0x7BFF and 0xFBFF, does not mark the step.
- R3: `overflow_flag` reads 1 from the cycle after the first non-finite word of a step. Later finite words do not clear it. Only the next `step_start` clears it, one cycle later.
- R4: In the cycle after the accepted word that carries `grad_last`, `decision_valid` is 1. `decision_commit` is 1 for a clean step and 0 for an overflowed step. Both hold until the next `step_start`, and `decision_valid` reads 0 in the cycle after that pulse.
- R5: An overflowed step lowers `scale_exp` by one, but not below MIN_EXP (0). It also sets the clean-step count to zero.
- R6: A clean step adds one to the clean-step count. When the count reaches the growth interval, `scale_exp` rises by one, but not above MAX_EXP (24), and the count returns to zero.
- R7: A `growth_interval` of 0 selects the default interval of 2000 clean steps.
- R8: A word is ignored in three cases: when no step is open (before the first `step_start`, or after the last word of a step), and when it arrives in the same cycle as `step_start`.
- R9: `scale_exp` changes only in the cycle in which a step's decision appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_start | input | 1 | Opens a new step; clears the flag and the decision |
| grad_valid | input | 1 | A gradient word is present |
| grad_last | input | 1 | The present word is the last of the step |
| grad_data | input | 16 | Half-precision gradient word |
| growth_interval | input | 16 | Clean steps needed before the scale grows; 0 selects 2000 |
| scale_exp | output | 6 | Current scale exponent (scale is 2^scale_exp) |
| decision_valid | output | 1 | A decision for the closed step is present |
| decision_commit | output | 1 | 1 commits the update, 0 skips it (meaningful while decision_valid) |
| overflow_flag | output | 1 | A non-finite word was seen in the current or last step |

## Verification
The embedded properties assume two things about the inputs. First, `rst` is synchronous. Second, `growth_interval` does not change in the middle of a step. Under these assumptions, every change of the scale lines up with a rising `decision_valid`.

The stimulus changes `growth_interval` only between steps. It does put words outside open steps and on the `step_start` cycle, because the block must show that it ignores them. It never puts `step_start` and `grad_last` in the same cycle. A behavioural model of the exponent, the clean count and the verdict is compared against the ports on every cycle.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  localparam int FP_EXP_W = 5;
  localparam int FP_MAN_W = 10;
  localparam int FP_W     = 1 + FP_EXP_W + FP_MAN_W;

  // Exponent field all ones: infinity or NaN
  function automatic logic fp_nonfinite(input logic [FP_W-1:0] w);
    return &w[FP_W-2 -: FP_EXP_W];
  endfunction
endpackage

// File: rtl/lsc_word_check.sv
module lsc_word_check
  import lsc_pkg::*;
(
  input  logic            word_ok,
  input  logic [FP_W-1:0] word,
  output logic            word_bad
);
  always_comb word_bad = word_ok & fp_nonfinite(word);
endmodule

// File: rtl/lsc_step_tracker.sv
module lsc_step_tracker (
  input  logic clk,
  input  logic rst,
  input  logic step_start,
  input  logic grad_valid,
  input  logic grad_last,
  input  logic word_bad,
  output logic accept,
  output logic step_end,
  output logic step_skip,
  output logic overflow_flag,
  output logic decision_valid,
  output logic decision_commit
);
  logic in_step;
  logic flag_base;

  // Words count only inside an open step and never on the opening cycle
  assign accept    = grad_valid & in_step & ~step_start;
  assign step_end  = accept & grad_last;
  assign flag_base = step_start ? 1'b0 : overflow_flag;
  assign step_skip = flag_base | word_bad;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_step         <= 1'b0;
      overflow_flag   <= 1'b0;
      decision_valid  <= 1'b0;
      decision_commit <= 1'b0;
    end else begin
      overflow_flag <= flag_base | word_bad;
      if (step_start) begin
        in_step        <= 1'b1;
        decision_valid <= 1'b0;
      end else if (step_end) begin
        in_step         <= 1'b0;
        decision_valid  <= 1'b1;
        decision_commit <= ~step_skip;
      end
    end
  end

  AST_STICKY_FLAG: assert property (@(posedge clk) disable iff (rst)
    overflow_flag && !step_start |=> overflow_flag); // R3
  AST_DECISION_HELD: assert property (@(posedge clk) disable iff (rst)
    decision_valid && !step_start |=> decision_valid && $stable(decision_commit)); // R4
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    step_start |=> !decision_valid && !overflow_flag); // R4
endmodule

// File: rtl/lsc_scale_reg.sv
module lsc_scale_reg #(
  parameter int EXP_W       = 6,
  parameter int CNT_W       = 16,
  parameter int INIT_EXP    = 15,
  parameter int MIN_EXP     = 0,
  parameter int MAX_EXP     = 24,
  parameter int DEF_GROWTH  = 2000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_end,
  input  logic             step_skip,
  input  logic [CNT_W-1:0] growth_interval,
  output logic [EXP_W-1:0] scale_exp
);
  localparam logic [EXP_W-1:0] EXP_LO   = EXP_W'(MIN_EXP);
  localparam logic [EXP_W-1:0] EXP_HI   = EXP_W'(MAX_EXP);
  localparam logic [EXP_W-1:0] EXP_INIT = EXP_W'(INIT_EXP);
  localparam logic [CNT_W-1:0] IV_DEF   = CNT_W'(DEF_GROWTH);

  logic [CNT_W-1:0] clean_cnt;
  logic [CNT_W-1:0] eff_iv;
  logic [CNT_W:0]   cnt_inc;
  logic             grow_now;

  assign eff_iv   = (growth_interval == '0) ? IV_DEF : growth_interval;
  assign cnt_inc  = {1'b0, clean_cnt} + 1'b1;
  assign grow_now = cnt_inc >= {1'b0, eff_iv};

  always_ff @(posedge clk) begin
    if (rst) begin
      scale_exp <= EXP_INIT;
      clean_cnt <= '0;
    end else if (step_end) begin
      if (step_skip) begin
        clean_cnt <= '0;
        if (scale_exp > EXP_LO) scale_exp <= scale_exp - 1'b1;
      end else if (grow_now) begin
        clean_cnt <= '0;
        if (scale_exp < EXP_HI) scale_exp <= scale_exp + 1'b1;
      end else begin
        clean_cnt <= cnt_inc[CNT_W-1:0];
      end
    end
  end

  AST_EXP_BOUNDS: assert property (@(posedge clk) disable iff (rst)
    scale_exp >= EXP_LO && scale_exp <= EXP_HI); // R5
  AST_SKIP_LOWERS: assert property (@(posedge clk) disable iff (rst)
    step_end && step_skip |=> scale_exp == (($past(scale_exp) > EXP_LO) ? $past(scale_exp) - 1'b1 : EXP_LO)); // R5
  AST_CLEAN_NO_DROP: assert property (@(posedge clk) disable iff (rst)
    step_end && !step_skip |=> scale_exp >= $past(scale_exp)); // R6
endmodule

// File: rtl/loss_scale_ctrl.sv
module loss_scale_ctrl
  import lsc_pkg::*;
#(
  parameter int EXP_W      = 6,
  parameter int CNT_W      = 16,
  parameter int INIT_EXP   = 15,
  parameter int MIN_EXP    = 0,
  parameter int MAX_EXP    = 24,
  parameter int DEF_GROWTH = 2000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_start,
  input  logic             grad_valid,
  input  logic             grad_last,
  input  logic [FP_W-1:0]  grad_data,
  input  logic [CNT_W-1:0] growth_interval,
  output logic [EXP_W-1:0] scale_exp,
  output logic             decision_valid,
  output logic             decision_commit,
  output logic             overflow_flag
);
  logic accept, word_bad, step_end, step_skip;

  lsc_word_check u_check (
    .word_ok  (accept),
    .word     (grad_data),
    .word_bad (word_bad)
  );

  lsc_step_tracker u_track (
    .clk             (clk),
    .rst             (rst),
    .step_start      (step_start),
    .grad_valid      (grad_valid),
    .grad_last       (grad_last),
    .word_bad        (word_bad),
    .accept          (accept),
    .step_end        (step_end),
    .step_skip       (step_skip),
    .overflow_flag   (overflow_flag),
    .decision_valid  (decision_valid),
    .decision_commit (decision_commit)
  );

  lsc_scale_reg #(
    .EXP_W(EXP_W), .CNT_W(CNT_W), .INIT_EXP(INIT_EXP),
    .MIN_EXP(MIN_EXP), .MAX_EXP(MAX_EXP), .DEF_GROWTH(DEF_GROWTH)
  ) u_scale (
    .clk             (clk),
    .rst             (rst),
    .step_end        (step_end),
    .step_skip       (step_skip),
    .growth_interval (growth_interval),
    .scale_exp       (scale_exp)
  );

  AST_EXP_AT_DECISION: assert property (@(posedge clk) disable iff (rst)
    !$stable(scale_exp) |-> $rose(decision_valid)); // R9
  AST_SKIP_HAS_FLAG: assert property (@(posedge clk) disable iff (rst)
    decision_valid && !decision_commit |-> overflow_flag); // R2
endmodule

// File: tb/tb_loss_scale_ctrl.sv
`timescale 1ns/1ps
module tb_loss_scale_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        step_start = 1'b0, grad_valid = 1'b0, grad_last = 1'b0;
  logic [15:0] grad_data = 16'h0;
  logic [15:0] growth_interval = 16'd3;
  logic [5:0]  scale_exp;
  logic        decision_valid, decision_commit, overflow_flag;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  loss_scale_ctrl dut (
    .clk(clk), .rst(rst), .step_start(step_start), .grad_valid(grad_valid),
    .grad_last(grad_last), .grad_data(grad_data), .growth_interval(growth_interval),
    .scale_exp(scale_exp), .decision_valid(decision_valid),
    .decision_commit(decision_commit), .overflow_flag(overflow_flag)
  );

  // Behavioural reference model
  int m_exp = 15, m_cnt = 0, m_dv = 0, m_cm = 0, m_flag = 0, m_in = 0;
  always @(posedge clk) begin
    int iv; bit acc, bad;
    if (rst) begin
      m_exp = 15; m_cnt = 0; m_dv = 0; m_cm = 0; m_flag = 0; m_in = 0;
    end else begin
      iv  = (growth_interval == 0) ? 2000 : int'(growth_interval);
      acc = grad_valid && m_in != 0 && !step_start;
      bad = acc && (grad_data[14:10] == 5'b11111);
      if (step_start) begin m_in = 1; m_flag = 0; m_dv = 0; end
      if (bad) m_flag = 1;
      if (acc && grad_last) begin
        m_in = 0; m_dv = 1; m_cm = m_flag ? 0 : 1;
        if (m_flag != 0) begin
          m_cnt = 0; if (m_exp > 0) m_exp--;
        end else if (m_cnt + 1 >= iv) begin
          m_cnt = 0; if (m_exp < 24) m_exp++;
        end else m_cnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) if (!rst && !done) begin
    chk(int'(scale_exp) == m_exp, "R5/R6/R9 scale_exp vs model", scale_exp, m_exp);
    chk(int'(decision_valid) == m_dv, "R4 decision_valid vs model", decision_valid, m_dv);
    if (m_dv != 0) chk(int'(decision_commit) == m_cm, "R4 decision_commit vs model", decision_commit, m_cm);
    chk(int'(overflow_flag) == m_flag, "R3 overflow_flag vs model", overflow_flag, m_flag);
  end

  task automatic tick(); @(negedge clk); endtask
  task automatic start_step(); step_start = 1; tick(); step_start = 0; endtask
  task automatic send(input logic [15:0] w, input bit last);
    grad_valid = 1; grad_data = w; grad_last = last; tick();
    grad_valid = 0; grad_last = 0;
  endtask
  task automatic run_step(input int n, input logic [15:0] bad, input int pos);
    start_step();
    for (int i = 0; i < n; i++) send((i == pos) ? bad : 16'h3C00, i == n - 1);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    tick(); tick(); rst = 0; tick();
    chk(scale_exp == 6'd15, "R1 reset scale", scale_exp, 15);
    chk(!decision_valid, "R1 reset decision", decision_valid, 0);
    chk(!overflow_flag, "R1 reset flag", overflow_flag, 0);

    send(16'h7C00, 1);                      // no step open: R8
    chk(!overflow_flag && !decision_valid, "R8 word before first step", overflow_flag, 0);
    run_step(2, 16'h0, -1);
    chk(decision_valid && decision_commit, "R4 clean commit", decision_commit, 1);

    run_step(3, 16'h7C00, 1);               // +inf
    chk(!decision_commit, "R2 inf skips", decision_commit, 0);
    chk(scale_exp == 6'd14, "R5 skip halves", scale_exp, 14);

    start_step(); send(16'hFC00, 0);        // -inf, mid-step
    chk(overflow_flag, "R3 flag set", overflow_flag, 1);
    chk(scale_exp == 6'd14, "R9 no change mid-step", scale_exp, 14);
    send(16'h3C00, 0);
    chk(overflow_flag, "R3 flag sticky", overflow_flag, 1);
    send(16'h3C00, 1);
    chk(!decision_commit && scale_exp == 6'd13, "R3 sticky skip", scale_exp, 13);

    run_step(2, 16'h7E01, 0);               // NaN
    chk(!decision_commit && scale_exp == 6'd12, "R2 NaN skips", scale_exp, 12);

    run_step(2, 16'h7BFF, 0);               // max finite
    chk(decision_commit, "R2 max finite commits", decision_commit, 1);
    run_step(2, 16'hFBFF, 1);
    chk(decision_commit && scale_exp == 6'd12, "R6 count 2 no growth", scale_exp, 12);
    run_step(1, 16'h0, -1);
    chk(scale_exp == 6'd13, "R6 growth at interval", scale_exp, 13);

    run_step(1, 16'h0, -1); run_step(1, 16'h0, -1);
    run_step(1, 16'h7C01, 0);               // resets count
    run_step(1, 16'h0, -1); run_step(1, 16'h0, -1);
    chk(scale_exp == 6'd12, "R5 count cleared by skip", scale_exp, 12);
    run_step(1, 16'h0, -1);
    chk(scale_exp == 6'd13, "R6 growth after reset count", scale_exp, 13);

    repeat (4) tick();
    chk(decision_valid && decision_commit, "R4 decision held", decision_valid, 1);
    send(16'h7C00, 1);                      // after last: R8
    chk(!overflow_flag && decision_commit, "R8 word after last", overflow_flag, 0);

    step_start = 1; grad_valid = 1; grad_data = 16'h7C00; tick();
    step_start = 0; grad_valid = 0;
    chk(!decision_valid, "R4 start drops decision", decision_valid, 0);
    chk(!overflow_flag, "R8 start-cycle word ignored", overflow_flag, 0);
    send(16'h3C00, 1);
    chk(decision_commit, "R8 start-cycle word no effect", decision_commit, 1);

    for (int k = 0; k < 20; k++) run_step(1, 16'hFFFF, 0);
    chk(scale_exp == 6'd0, "R5 clamp at min", scale_exp, 0);

    growth_interval = 16'd1;
    for (int k = 0; k < 30; k++) run_step(1, 16'h0, -1);
    chk(scale_exp == 6'd24, "R6 clamp at max", scale_exp, 24);

    run_step(1, 16'h7C00, 0);
    growth_interval = 16'd0;
    for (int k = 0; k < 1999; k++) run_step(1, 16'h0, -1);
    chk(scale_exp == 6'd23, "R7 no growth at 1999", scale_exp, 23);
    run_step(1, 16'h0, -1);
    chk(scale_exp == 6'd24, "R7 growth at 2000", scale_exp, 24);

    tick();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule